// File: doc/BRIEF.md
# Periodic Serial ADC Sampling Controller

This block is the host side of a link to a 12-bit successive-approximation ADC with a three-wire serial port and a two-input multiplexer. It runs from one system clock and produces the convert strobe, the shift clock and the serial configuration word. It also captures the serial result bit by bit. Each frame it raises the convert line for a fixed conversion time and then drops it. It then clocks twelve shift pulses: the two-bit mux word goes out on the falling edges and the result comes in on the rising ones.

The mux word sent during a transfer selects the input for the *following* sample. For this reason the controller keeps the word from the previous transfer and attaches it to each result as a channel tag. Results leave over a valid/ready handshake. A result that replaces one not yet taken raises an overrun flag. The shift-clock half period and the frame period are run-time inputs. They are sampled once per frame and raised to legal floors when set too low.

Top module: `adc_sampler_ctrl`

## Requirements
- R1: While `rst_n` is low, `conv_o`, `sck_o`, `sdi_o`, `res_valid_o` and `overrun_o` are 0, and `res_data_o` and `res_tag_o` are 0.
- R2: The first frame starts on the first clock edge after reset is released. Each frame starts when `conv_o` goes high. `half_div_i`, `period_i` and `mux_cfg_i` are sampled only on that start edge, and changes at any other time have no effect on the frame.
- R3: `conv_o` stays high for exactly CONV_CYC clocks and then stays low until the next frame starts.
- R4: `sck_o` idles low and is never high while `conv_o` is high. After `conv_o` falls it stays low for H clocks, then gives exactly DATA_W pulses, each H clocks high and then H clocks low. H is the effective half period.
- R5: `sdi_o` carries `mux_cfg_i[1]` (1 = single-ended) from the fall of `conv_o` to the end of the first high phase of `sck_o`. It then carries `mux_cfg_i[0]` (odd channel / swapped sign) until the end of the second high phase, and 0 at all other times.
- R6: `sdo_i` is sampled on the clock at which `sck_o` goes high, first bit as MSB. The DATA_W-bit word appears on `res_data_o` with `res_valid_o` high CONV_CYC + (2·DATA_W+1)·H clocks after the frame start.
- R7: `res_tag_o` holds the mux word sent in the frame before the one that delivered the result. For the first result after reset it holds 2'b10 (single-ended, channel 0).
- R8: Once high, `res_valid_o` stays high, and `res_data_o` and `res_tag_o` stay unchanged, until a clock at which `res_ready_i` is high. A clock with both high takes the result.
- R9: If a new result arrives while an earlier one is still held and not being taken, the new result replaces it and `overrun_o` goes to 1. `overrun_o` returns to 0 on the next clock at which a result is taken.
- R10: H equals `half_div_i` raised to MIN_HALF. The frame period in clocks equals `period_i` raised to the larger of MIN_PERIOD and CONV_CYC + (2·DATA_W+1)·H + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div_i | input | DIV_W | Requested shift-clock half period in clocks |
| period_i | input | PER_W | Requested frame period in clocks |
| mux_cfg_i | input | 2 | Mux word: bit 1 single-ended, bit 0 odd/sign |
| sdo_i | input | 1 | Serial result from the converter |
| res_ready_i | input | 1 | Consumer accepts the result |
| conv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Shift clock |
| sdi_o | output | 1 | Serial mux word to the converter |
| res_valid_o | output | 1 | Result available |
| res_data_o | output | DATA_W | Captured conversion result |
| res_tag_o | output | 2 | Mux word that produced the result |
| overrun_o | output | 1 | A held result was overwritten |

## Verification
A corrupted phase counter or frame counter shows up at once as a misplaced edge on `conv_o` or `sck_o`. The bench compares every clock against a model computed from division of the elapsed frame time, so such an error is caught in the very cycle it occurs. A slipped capture point or a wrong shift order shows only at the end of the frame, as a wrong `res_data_o`, about CONV_CYC + 25·H clocks after the start. A lost mux-word history is hidden until the following frame, when `res_tag_o` disagrees with the word the bench sent one frame earlier. Handshake faults appear on the first clock that `res_ready_i` is held low across a result.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef struct packed {
    logic single_end;
    logic odd_sel;
  } mux_word_t;

  localparam mux_word_t MUX_RESET = '{single_end: 1'b1, odd_sel: 1'b0};

  typedef enum logic [2:0] {PH_IDLE, PH_CONV, PH_LEAD, PH_HIGH, PH_LOW} phase_e;

  function automatic int unsigned eff_half(int unsigned req, int unsigned floor_h);
    return (req < floor_h) ? floor_h : req;
  endfunction

  // shortest legal frame: conversion, lead-in, all pulses, one idle clock
  function automatic int unsigned frame_floor(int unsigned conv_cyc, int unsigned half,
                                              int unsigned bits);
    return conv_cyc + half * (2 * bits + 1) + 1;
  endfunction

  function automatic int unsigned eff_period(int unsigned req, int unsigned min_per,
                                             int unsigned fl);
    int unsigned lo;
    lo = (min_per > fl) ? min_per : fl;
    return (req < lo) ? lo : req;
  endfunction

endpackage

// File: rtl/adc_host_timer.sv
module adc_host_timer
  import adc_host_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int DIV_W      = 8,
  parameter int PER_W      = 16,
  parameter int CONV_CYC   = 640,
  parameter int MIN_PERIOD = 800,
  parameter int MIN_HALF   = 6,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [PER_W-1:0] period_i,
  input  mux_word_t        mux_cfg_i,
  output logic             frame_start_o,
  output logic [DIV_W-1:0] half_o,
  output mux_word_t        cfg_o
);

  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] per_q;
  int unsigned      half_w;
  int unsigned      floor_w;
  int unsigned      per_w;

  always_comb begin
    half_w  = eff_half(32'(half_div_i), MIN_HALF);
    floor_w = frame_floor(CONV_CYC, half_w, DATA_W);
    per_w   = eff_period(32'(period_i), MIN_PERIOD, floor_w);
  end

  assign frame_start_o = (ph_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      per_q  <= '1;
      half_o <= DIV_W'(MIN_HALF);
      cfg_o  <= MUX_RESET;
    end else begin
      if (frame_start_o) begin
        per_q  <= CNT_W'(per_w);
        half_o <= DIV_W'(half_w);
        cfg_o  <= mux_cfg_i;
      end
      ph_q <= (ph_q == per_q - 1'b1) ? '0 : ph_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int DIV_W    = 8,
  parameter int CONV_CYC = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [DIV_W-1:0]  half_i,
  input  mux_word_t         cfg_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic              publish_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int CW    = $clog2(CONV_CYC + 1);
  localparam int SEG_W = (CW > DIV_W) ? CW : DIV_W;
  localparam int BIT_W = $clog2(DATA_W + 1);

  phase_e            state_q;
  logic [SEG_W-1:0]  seg_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SEG_W-1:0]  half_load;
  logic              seg_done;
  logic              last_bit;
  logic              rise_w;

  assign half_load = SEG_W'(half_i - 1'b1);
  assign seg_done  = (seg_q == '0);
  assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));
  assign rise_w    = !frame_start_i && seg_done &&
                     (state_q == PH_LEAD || (state_q == PH_LOW && !last_bit));
  assign publish_o = !frame_start_i && seg_done && state_q == PH_LOW && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      seg_q   <= '0;
      bit_q   <= '0;
      conv_o  <= 1'b0;
      sck_o   <= 1'b0;
      sdi_o   <= 1'b0;
      word_o  <= '0;
    end else if (frame_start_i) begin
      state_q <= PH_CONV;
      seg_q   <= SEG_W'(CONV_CYC - 1);
      conv_o  <= 1'b1;
      sck_o   <= 1'b0;
    end else begin
      if (!seg_done) seg_q <= seg_q - 1'b1;
      unique case (state_q)
        PH_CONV: if (seg_done) begin
          state_q <= PH_LEAD;
          conv_o  <= 1'b0;
          sdi_o   <= cfg_i.single_end;
          seg_q   <= half_load;
        end
        PH_LEAD: if (seg_done) begin
          state_q <= PH_HIGH;
          sck_o   <= 1'b1;
          word_o  <= {word_o[DATA_W-2:0], sdo_i};
          bit_q   <= '0;
          seg_q   <= half_load;
        end
        PH_HIGH: if (seg_done) begin
          state_q <= PH_LOW;
          sck_o   <= 1'b0;
          sdi_o   <= (bit_q == '0) ? cfg_i.odd_sel : 1'b0;
          seg_q   <= half_load;
        end
        PH_LOW: if (seg_done) begin
          if (last_bit) begin
            state_q <= PH_IDLE;
          end else begin
            state_q <= PH_HIGH;
            sck_o   <= 1'b1;
            word_o  <= {word_o[DATA_W-2:0], sdo_i};
            bit_q   <= bit_q + 1'b1;
            seg_q   <= half_load;
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  // checker state for the assertions below
  int unsigned conv_run_q;
  int unsigned pulse_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_run_q  <= 0;
      pulse_cnt_q <= 0;
    end else begin
      conv_run_q  <= conv_o ? conv_run_q + 1 : 0;
      pulse_cnt_q <= frame_start_i ? 0 : (rise_w ? pulse_cnt_q + 1 : pulse_cnt_q);
    end
  end

  assert_conv_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> conv_run_q == CONV_CYC);

  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    publish_o |-> pulse_cnt_q == DATA_W);

endmodule

// File: rtl/adc_host_outbuf.sv
module adc_host_outbuf
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              publish_i,
  input  logic [DATA_W-1:0] word_i,
  input  mux_word_t         cfg_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output mux_word_t         tag_o,
  output logic              overrun_o
);

  mux_word_t prev_q;
  logic      accept_w;
  logic      clobber_w;

  assign accept_w  = valid_o && ready_i;
  assign clobber_w = publish_i && valid_o && !ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= MUX_RESET;
      valid_o   <= 1'b0;
      data_o    <= '0;
      tag_o     <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (publish_i) begin
        data_o  <= word_i;
        tag_o   <= prev_q;
        prev_q  <= cfg_i;
        valid_o <= 1'b1;
      end else if (accept_w) begin
        valid_o <= 1'b0;
      end
      if (clobber_w)     overrun_o <= 1'b1;
      else if (accept_w) overrun_o <= 1'b0;
    end
  end

  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !publish_i) |=> valid_o && $stable(data_o) && $stable(tag_o));

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> valid_o && $past(valid_o) && !$past(ready_i));

endmodule

// File: rtl/adc_sampler_ctrl.sv
module adc_sampler_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int DIV_W      = 8,
  parameter int PER_W      = 16,
  parameter int CONV_CYC   = 640,
  parameter int MIN_PERIOD = 800,
  parameter int MIN_HALF   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [1:0]        mux_cfg_i,
  input  logic              sdo_i,
  input  logic              res_ready_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [1:0]        res_tag_o,
  output logic              overrun_o
);

  localparam int FLOOR_MAX = CONV_CYC + ((1 << DIV_W) - 1) * (2 * DATA_W + 1) + 1;
  localparam int FLOOR_W   = $clog2(FLOOR_MAX + 1);
  localparam int CNT_W     = (PER_W > FLOOR_W) ? PER_W : FLOOR_W;

  logic              frame_start;
  logic [DIV_W-1:0]  half_q;
  mux_word_t         cfg_q;
  logic              publish;
  logic [DATA_W-1:0] word;
  mux_word_t         tag_w;

  adc_host_timer #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W), .CONV_CYC(CONV_CYC),
    .MIN_PERIOD(MIN_PERIOD), .MIN_HALF(MIN_HALF), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .half_div_i(half_div_i), .period_i(period_i),
    .mux_cfg_i(mux_word_t'(mux_cfg_i)), .frame_start_o(frame_start),
    .half_o(half_q), .cfg_o(cfg_q)
  );

  adc_host_seq #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .CONV_CYC(CONV_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .half_i(half_q),
    .cfg_i(cfg_q), .sdo_i(sdo_i), .conv_o(conv_o), .sck_o(sck_o), .sdi_o(sdi_o),
    .publish_o(publish), .word_o(word)
  );

  adc_host_outbuf #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .publish_i(publish), .word_i(word), .cfg_i(cfg_q),
    .ready_i(res_ready_i), .valid_o(res_valid_o), .data_o(res_data_o),
    .tag_o(tag_w), .overrun_o(overrun_o)
  );

  assign res_tag_o = tag_w;

  // frame spacing checker
  int unsigned gap_q;
  logic        started_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= 0;
      started_q <= 1'b0;
    end else begin
      gap_q     <= frame_start ? 1 : gap_q + 1;
      started_q <= started_q | frame_start;
    end
  end

  assert_frame_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && started_q) |-> gap_q >= MIN_PERIOD);

  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> !sck_o);

endmodule

// File: tb/tb_adc_sampler_ctrl.sv
module tb_adc_sampler_ctrl;

  localparam int DATA_W = 12, DIV_W = 8, PER_W = 16;
  localparam int CC = 20, MINP = 100, MINH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd3;
  logic [PER_W-1:0] period = 16'd150;
  logic [1:0] mux_cfg = 2'b10;
  logic sdo = 1'b0;
  logic ready = 1'b1;
  logic conv_o, sck_o, sdi_o, res_valid_o, overrun_o;
  logic [DATA_W-1:0] res_data_o;
  logic [1:0] res_tag_o;

  always #2.5 clk = ~clk;

  adc_sampler_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W), .CONV_CYC(CC),
                     .MIN_PERIOD(MINP), .MIN_HALF(MINH)) dut (
    .clk(clk), .rst_n(rst_n), .half_div_i(half_div), .period_i(period),
    .mux_cfg_i(mux_cfg), .sdo_i(sdo), .res_ready_i(ready), .conv_o(conv_o),
    .sck_o(sck_o), .sdi_o(sdi_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_tag_o(res_tag_o), .overrun_o(overrun_o));

  int checks = 0;
  int fails = 0;

  function automatic int gen_word(int n);
    if (n == 1) return 12'hFFF;
    if (n == 2) return 0;
    return (n * 2517 + 935) & 12'hFFF;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // converter model: first bit after convert falls, next bit on each shift-clock fall
  int sdo_fn = -1;
  int sdo_idx = 0;
  int sdo_word = 0;
  always @(negedge conv_o) begin
    sdo_fn++;
    sdo_word = gen_word(sdo_fn);
    sdo_idx = 0;
    sdo = sdo_word[DATA_W-1];
  end
  always @(negedge sck_o) begin
    sdo_idx++;
    sdo = (sdo_idx < DATA_W) ? sdo_word[DATA_W-1-sdo_idx] : 1'b0;
  end

  // behavioural reference: elapsed time in frame, decoded by division
  int e = 0, hm = MINH, pm = MINP, fn = -1;
  int cfgm = 2, prevm = 2;
  int x_conv = 0, x_sck = 0, x_sdi = 0, x_valid = 0, x_data = 0, x_tag = 0, x_ovr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; fn = -1; prevm = 2;
      x_conv = 0; x_sck = 0; x_sdi = 0; x_valid = 0; x_data = 0; x_tag = 0; x_ovr = 0;
    end else begin
      int u, fl;
      bit acc;
      acc = (x_valid == 1) && ready;
      if (e == 0) begin
        hm = (int'(half_div) < MINH) ? MINH : int'(half_div);
        fl = CC + hm * (2 * DATA_W + 1) + 1;
        pm = int'(period);
        if (pm < MINP) pm = MINP;
        if (pm < fl) pm = fl;
        cfgm = int'(mux_cfg);
        fn++;
      end
      if (e == CC + hm * (2 * DATA_W + 1)) begin
        if (x_valid == 1 && !acc) x_ovr = 1;
        else if (acc) x_ovr = 0;
        x_data = gen_word(fn);
        x_tag = prevm;
        prevm = cfgm;
        x_valid = 1;
      end else if (acc) begin
        x_valid = 0;
        x_ovr = 0;
      end
      x_conv = (e < CC) ? 1 : 0;
      x_sck = 0;
      x_sdi = 0;
      if (e >= CC) begin
        u = e - CC;
        if (u >= hm && (u - hm) / (2 * hm) < DATA_W && (u - hm) % (2 * hm) < hm) x_sck = 1;
        if (u < 2 * hm) x_sdi = (cfgm >> 1) & 1;
        else if (u < 4 * hm) x_sdi = cfgm & 1;
      end
      e = (e == pm - 1) ? 0 : e + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "conv", int'(conv_o), 0);
      chk("R1", "sck", int'(sck_o), 0);
      chk("R1", "sdi", int'(sdi_o), 0);
      chk("R1", "valid", int'(res_valid_o), 0);
      chk("R1", "overrun", int'(overrun_o), 0);
      chk("R1", "data", int'(res_data_o), 0);
      chk("R1", "tag", int'(res_tag_o), 0);
    end else begin
      chk("R2,R3,R10", "conv", int'(conv_o), x_conv);
      chk("R4,R10", "sck", int'(sck_o), x_sck);
      chk("R5", "sdi", int'(sdi_o), x_sdi);
      chk("R8", "valid", int'(res_valid_o), x_valid);
      chk("R6", "data", int'(res_data_o), x_data);
      chk("R7", "tag", int'(res_tag_o), x_tag);
      chk("R9", "overrun", int'(overrun_o), x_ovr);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    // R2, R5, R7: mux word changed mid-frame every frame
    mux_cfg = 2'b01; wait_cyc(170);
    mux_cfg = 2'b11; wait_cyc(150);
    mux_cfg = 2'b00; wait_cyc(150);
    mux_cfg = 2'b10; half_div = 8'd4; wait_cyc(150);
    // R9: consumer stalls across several results
    ready = 1'b0; mux_cfg = 2'b01; wait_cyc(460);
    ready = 1'b1; wait_cyc(150);
    // R10: requests below both floors
    half_div = 8'd0; period = 16'd5; mux_cfg = 2'b11; wait_cyc(330);
    half_div = 8'd8; period = 16'd5; wait_cyc(460);
    // R8: ready toggling with a long period
    half_div = 8'd3; period = 16'd400;
    for (int i = 0; i < 1200; i++) begin
      ready = (i % 3 == 0);
      if (i % 250 == 0) mux_cfg = 2'(i / 250);
      @(negedge clk);
    end
    ready = 1'b1;
    wait_cyc(50);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule